// File: doc/BRIEF.md
# Dual-Mode Converter Result Bus Formatter

This block places converter results onto a shared pad bus of `W` lines (10 by default). Every line has its own data and drive-enable output. A one-cycle conversion strobe captures a result into a holding register. The block then presents the held result in one of two ways:

- **Wide mode:** the whole word is driven on all lines.
- **Split mode:** the word is sent as two 8-bit transfers on the upper eight lines within one conversion period. A phase output shows which of the two transfers is on the bus.

The mode comes from a configuration bit. It is taken up only when a strobe arrives, so both transfers of a pair always come from the same result in the same format.

The drivers are gated by an active-low output enable. The upper eight lines are also shared with a parallel control port. When parallel control is active and the read/not-write level is 0, the block releases those lines and flags that they carry input data. When that request ends, the drivers come back one cycle later. A driver that is turning off therefore never overlaps with one that is turning on.

Top module: `adc_bus_fmt`

## Requirements
- R1: After reset the held result is 0, the mode is wide and the phase is 0. With `oe_ni` low, all lines are enabled and drive 0.
- R2: While `oe_ni` is 1, every line enable in `bus_oe_o` is 0 and `bus_o` is 0. This takes effect in the same cycle.
- R3: In wide mode, `bus_o` equals the held result. Line `W-1` carries the MSB and line 0 carries the LSB.
- R4: In split mode, for the first `HALF_CYC` cycles after a strobe, `phase_o` is 0 and lines [W-1:W-8] carry held bits [W-1:W-8]. The lower `W-8` lines are enabled and driven low.
- R5: In split mode, from the `HALF_CYC`-th cycle after a strobe until the next strobe, `phase_o` is 1. The upper lines carry held bits [W-9:0], left-justified, with zeros below. The lower lines stay low.
- R6: A result is captured only in a cycle where `conv_strobe_i` is 1. Changes on `result_i` at other times do not affect `bus_o`.
- R7: The mode (`split_cfg_i`: 1 = split, 0 = wide) is sampled only on a strobe. A change between strobes leaves both the format and `phase_o` unchanged until the next strobe.
- R8: While `par_ctrl_i` is 1 and `rnw_i` is 0, the upper eight enables are 0 in the same cycle and `ctrl_in_vld_o` is 1. `ctrl_in_o` always shows the upper eight lines of `bus_i`.
- R9: In the first cycle after a control-input request ends, the upper eight enables remain 0. They return to following `oe_ni` in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_strobe_i | input | 1 | One-cycle strobe: capture result, restart sequencing |
| result_i | input | W | Converter result |
| split_cfg_i | input | 1 | Configured mode, 1 = split 8-bit transfers |
| oe_ni | input | 1 | Output enable, active low |
| par_ctrl_i | input | 1 | Parallel control mode active |
| rnw_i | input | 1 | Read/not-write; 0 turns upper lines into input |
| bus_i | input | W | Pad input values |
| bus_o | output | W | Pad output data, 0 where not driven |
| bus_oe_o | output | W | Per-line drive enable |
| phase_o | output | 1 | 1 while the second split transfer is presented |
| ctrl_in_o | output | 8 | Upper eight pad lines as control input |
| ctrl_in_vld_o | output | 1 | Upper lines are being used as input |

## Verification
The enables and the control-input flag react to `oe_ni`, `par_ctrl_i` and `rnw_i` in the same cycle. The exception is the one-cycle hold-off after an input request, which is due exactly one edge after the request drops. Captured data and the mode appear one edge after the strobe. `phase_o` rises `HALF_CYC` edges after that strobe edge.

The bench keeps a behavioural model that is updated on each rising edge. It compares every output at the following falling edge, so each result is checked in the cycle it is due. The inputs are then changed after the compare, at that same falling edge.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  typedef enum logic {
    FMT_WIDE  = 1'b0,
    FMT_SPLIT = 1'b1
  } fmt_mode_e;
endpackage

// File: rtl/fmt_seq.sv
module fmt_seq
  import fmt_pkg::*;
#(
  parameter int W        = 10,
  parameter int HALF_CYC = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strobe_i,
  input  logic [W-1:0] result_i,
  input  logic         split_cfg_i,
  output logic [W-1:0] hold_o,
  output fmt_mode_e    mode_o,
  output logic         second_o
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(HALF_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= '0;
      mode_o <= FMT_WIDE;
      cnt_q  <= '0;
    end else if (strobe_i) begin
      hold_o <= result_i;
      mode_o <= split_cfg_i ? FMT_SPLIT : FMT_WIDE;
      cnt_q  <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // saturating count: second transfer holds until next strobe
  assign second_o = (mode_o == FMT_SPLIT) && (cnt_q == CNT_MAX);
endmodule

// File: rtl/fmt_pack.sv
module fmt_pack
  import fmt_pkg::*;
#(
  parameter int W      = 10,
  parameter int BYTE_W = 8
) (
  input  logic [W-1:0] hold_i,
  input  fmt_mode_e    mode_i,
  input  logic         second_i,
  output logic [W-1:0] word_o
);
  localparam int LOW_W = W - BYTE_W;

  logic [BYTE_W-1:0] tail_byte;

  generate
    if (LOW_W == BYTE_W) begin : g_full
      assign tail_byte = hold_i[LOW_W-1:0];
    end else begin : g_pad
      assign tail_byte = {hold_i[LOW_W-1:0], {(BYTE_W-LOW_W){1'b0}}};
    end
  endgenerate

  always_comb begin
    word_o = hold_i;
    if (mode_i == FMT_SPLIT) begin
      word_o[LOW_W-1:0] = '0;
      word_o[W-1:LOW_W] = second_i ? tail_byte : hold_i[W-1:LOW_W];
    end
  end
endmodule

// File: rtl/fmt_dir.sv
module fmt_dir #(
  parameter int W      = 10,
  parameter int BYTE_W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         oe_ni,
  input  logic         par_ctrl_i,
  input  logic         rnw_i,
  output logic [W-1:0] line_en_o,
  output logic         in_req_o
);
  localparam int LOW_W = W - BYTE_W;

  logic in_req_q;

  assign in_req_o = par_ctrl_i & ~rnw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_req_q <= 1'b0;
    else         in_req_q <= in_req_o;
  end

  // release at once, re-drive one cycle late: no driver overlap
  assign line_en_o[LOW_W-1:0] = {LOW_W{~oe_ni}};
  assign line_en_o[W-1:LOW_W] = {BYTE_W{~oe_ni & ~in_req_o & ~in_req_q}};
endmodule

// File: rtl/adc_bus_fmt.sv
module adc_bus_fmt
  import fmt_pkg::*;
#(
  parameter int W        = 10,
  parameter int BYTE_W   = 8,
  parameter int HALF_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_strobe_i,
  input  logic [W-1:0]      result_i,
  input  logic              split_cfg_i,
  input  logic              oe_ni,
  input  logic              par_ctrl_i,
  input  logic              rnw_i,
  input  logic [W-1:0]      bus_i,
  output logic [W-1:0]      bus_o,
  output logic [W-1:0]      bus_oe_o,
  output logic              phase_o,
  output logic [BYTE_W-1:0] ctrl_in_o,
  output logic              ctrl_in_vld_o
);
  logic [W-1:0] hold;
  fmt_mode_e    mode;
  logic         second;
  logic [W-1:0] word;
  logic [W-1:0] line_en;

  fmt_seq #(.W(W), .HALF_CYC(HALF_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (conv_strobe_i),
    .result_i    (result_i),
    .split_cfg_i (split_cfg_i),
    .hold_o      (hold),
    .mode_o      (mode),
    .second_o    (second)
  );

  fmt_pack #(.W(W), .BYTE_W(BYTE_W)) u_pack (
    .hold_i   (hold),
    .mode_i   (mode),
    .second_i (second),
    .word_o   (word)
  );

  fmt_dir #(.W(W), .BYTE_W(BYTE_W)) u_dir (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .oe_ni      (oe_ni),
    .par_ctrl_i (par_ctrl_i),
    .rnw_i      (rnw_i),
    .line_en_o  (line_en),
    .in_req_o   (ctrl_in_vld_o)
  );

  assign bus_o     = word & line_en;
  assign bus_oe_o  = line_en;
  assign phase_o   = second;
  assign ctrl_in_o = bus_i[W-1:W-BYTE_W];
endmodule

// File: rtl/adc_bus_fmt_chk.sv
module adc_bus_fmt_chk #(
  parameter int W      = 10,
  parameter int BYTE_W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         conv_strobe_i,
  input logic         oe_ni,
  input logic         par_ctrl_i,
  input logic         rnw_i,
  input logic [W-1:0] bus_o,
  input logic [W-1:0] bus_oe_o,
  input logic         phase_o
);
  localparam int LOW_W = W - BYTE_W;

  assert_tristate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (bus_oe_o == '0 && bus_o == '0));

  assert_low_lines_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o && !oe_ni) |-> (bus_oe_o[LOW_W-1:0] == '1 && bus_o[LOW_W-1:0] == '0));

  assert_phase_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_o) |-> !$past(conv_strobe_i));

  assert_input_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_ctrl_i && !rnw_i) |-> (bus_oe_o[W-1:LOW_W] == '0));

  assert_turnaround_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_ctrl_i && !rnw_i) |=> (bus_oe_o[W-1:LOW_W] == '0));
endmodule

bind adc_bus_fmt adc_bus_fmt_chk #(.W(W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .conv_strobe_i (conv_strobe_i),
  .oe_ni         (oe_ni),
  .par_ctrl_i    (par_ctrl_i),
  .rnw_i         (rnw_i),
  .bus_o         (bus_o),
  .bus_oe_o      (bus_oe_o),
  .phase_o       (phase_o)
);

// File: tb/adc_bus_fmt_bench.sv
module adc_bus_fmt_bench;
  localparam int W    = 10;
  localparam int BW   = 8;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0, split_cfg = 1'b0, oe_n = 1'b0, par = 1'b0, rnw = 1'b1;
  logic [W-1:0] result = '0, bus_in = '0;
  logic [W-1:0] bus_o, bus_oe;
  logic phase;
  logic [BW-1:0] ctrl_in;
  logic ctrl_vld;

  int n_tests = 0, n_fail = 0;
  string force_tag = "";

  always #5 clk = ~clk;

  adc_bus_fmt u_adc_bus_fmt (
    .clk_i(clk), .rst_ni(rst_n), .conv_strobe_i(strobe), .result_i(result),
    .split_cfg_i(split_cfg), .oe_ni(oe_n), .par_ctrl_i(par), .rnw_i(rnw),
    .bus_i(bus_in), .bus_o(bus_o), .bus_oe_o(bus_oe), .phase_o(phase),
    .ctrl_in_o(ctrl_in), .ctrl_in_vld_o(ctrl_vld)
  );

  // behavioural reference
  int m_hold, m_split, m_cnt, m_inq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = 0; m_split = 0; m_cnt = 0; m_inq = 0;
    end else begin
      m_inq = (par && !rnw) ? 1 : 0;
      if (strobe) begin
        m_hold = int'(result); m_split = int'(split_cfg); m_cnt = 0;
      end else if (m_cnt < HALF) m_cnt++;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int inreq, upen, loen, ph, word, en, hi, lo;
    string tag;
    inreq = (par && !rnw) ? 1 : 0;
    loen  = oe_n ? 0 : 1;
    upen  = (!oe_n && !inreq && !m_inq) ? 1 : 0;
    ph    = (m_split == 1 && m_cnt >= HALF) ? 1 : 0;
    hi    = (m_hold / 4) % 256;
    lo    = m_hold % 4;
    if (m_split == 0) word = m_hold;
    else if (ph == 1) word = lo * 256;
    else              word = hi * 4;
    en = (upen ? 10'h3FC : 0) | (loen ? 3 : 0);
    if (force_tag != "")      tag = force_tag;
    else if (oe_n)            tag = "R2";
    else if (inreq)           tag = "R8";
    else if (m_inq)           tag = "R9";
    else if (m_split == 0)    tag = "R3";
    else if (ph == 1)         tag = "R5";
    else                      tag = "R4";
    check(tag, "bus_o", int'(bus_o), word & en);
    check(tag, "bus_oe_o", int'(bus_oe), en);
    check((m_split == 1) ? "R5" : tag, "phase_o", int'(phase), ph);
    check("R8", "ctrl_in_vld_o", int'(ctrl_vld), inreq);
    check("R8", "ctrl_in_o", int'(ctrl_in), int'(bus_in[W-1:2]));
  endtask

  // compare the previous cycle's results, then drive the next inputs
  task automatic step(logic s, logic [W-1:0] r);
    @(negedge clk);
    compare();
    force_tag = "";
    strobe = s;
    result = r;
  endtask

  task automatic period(logic [W-1:0] r, int len);
    step(1'b1, r);
    for (int k = 1; k < len; k++) step(1'b0, r ^ 10'h155);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bus_in = 10'h2C7;
    force_tag = "R1"; step(1'b0, '0);
    force_tag = "R1"; step(1'b0, '0);
    rst_n = 1'b1;
    force_tag = "R1"; step(1'b0, '0);

    // wide mode, several patterns
    period(10'h3FF, 4); period(10'h001, 4); period(10'h2A5, 4); period(10'h200, 5);
    // R6: result moves without a strobe
    step(1'b0, 10'h0F0); force_tag = "R6"; step(1'b0, 10'h30F);
    force_tag = "R6"; step(1'b0, 10'h111);

    // R7: configure split between strobes, no effect until next strobe
    split_cfg = 1'b1;
    force_tag = "R7"; step(1'b0, 10'h222);
    force_tag = "R7"; step(1'b0, 10'h222);
    force_tag = "R7"; step(1'b0, 10'h222);
    period(10'h2A5, 4); period(10'h3FF, 4); period(10'h001, 4); period(10'h156, 7);

    // R2: drivers off while split sequence runs
    oe_n = 1'b1; period(10'h3C3, 4); oe_n = 1'b0; period(10'h0AA, 4);

    // back to wide, change takes effect at strobe
    split_cfg = 1'b0;
    force_tag = "R7"; step(1'b0, 10'h000);
    period(10'h35A, 4);

    // R8 / R9: parallel control turnaround
    par = 1'b1; rnw = 1'b1; period(10'h1E1, 3);
    rnw = 1'b0; bus_in = 10'h15B; period(10'h0C3, 3);
    rnw = 1'b1; step(1'b0, 10'h0); step(1'b0, 10'h0); step(1'b0, 10'h0);
    split_cfg = 1'b1;
    rnw = 1'b0; step(1'b1, 10'h2F0); rnw = 1'b1; step(1'b0, 10'h0);
    step(1'b0, 10'h0); step(1'b0, 10'h0);
    par = 1'b0; rnw = 1'b0; period(10'h10F, 4);

    // mixed sweep
    for (int i = 0; i < 120; i++) begin
      split_cfg = i[2];
      oe_n      = (i % 11 == 7);
      par       = (i % 13 < 3);
      rnw       = (i % 5 != 1);
      bus_in    = W'(i * 37);
      period(W'(i * 97 + 13), 2 + (i % 5));
    end
    step(1'b0, '0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule